// File: doc/BRIEF.md
# Instruction Breakpoint Unit with Resume Flag

This block watches the address of every instruction as it begins and raises a debug fault request when that address equals one of a small set of programmable breakpoint addresses. Each breakpoint has its own address register and its own enable bit in a control register. A sticky status register records which breakpoints matched. Software clears that record by writing the status register.

A resume flag lets software step past a breakpoint it has just serviced. The flag is sampled when an instruction begins. While the flag is set, matches are still recorded in the status register, but no fault request is raised. An ordinary instruction clears the flag when it retires. Two classes of instruction behave differently at retirement. A flags-restoring instruction, such as a return from interrupt or a flags pop, loads the flag from the popped value. A control transfer that switches task leaves the flag unchanged. A direct load path also sets the flag to any value.

Top module: `dbg_brk_unit`

## Requirements
- R1: After reset the fault request is low, all status bits are 0, all enables are 0 and the resume flag is 0.
- R2: A write with `reg_sel` = i (0 to NUM_BP-1) loads breakpoint address register i with the full `reg_wdata` value. A later rewrite replaces the old address.
- R3: A write with `reg_sel` = NUM_BP (4 by default) loads the control register. Bit i of `reg_wdata` enables breakpoint i. A disabled breakpoint never sets its status bit and never causes a fault.
- R4: When `ist_vld` is high and `ist_addr` equals the address of an enabled breakpoint while the resume flag is clear, two things happen after the next clock edge. `dbg_fault` is high for exactly that one cycle, and the status bit of that breakpoint is set.
- R5: If several enabled breakpoints match the same start address, all of their status bits are set at the same edge.
- R6: Status bits stay set until software writes them. A write with `reg_sel` = NUM_BP+1 (5 by default) loads the status bits from the low NUM_BP bits of `reg_wdata`, and writing 0 clears them. A match in the same cycle as such a write is ORed into the written value.
- R7: The resume flag value at the start cycle governs the fault. When the flag is set, a matching enabled breakpoint still sets its status bit but `dbg_fault` stays low.
- R8: When `ret_vld` is high with `ret_cls` = 0 (ordinary) or 3 (other ordinary), the resume flag is cleared at the next edge.
- R9: When `ret_vld` is high with `ret_cls` = 1 (flags restore), the resume flag is loaded from `rf_ld_val`.
- R10: When `ret_vld` is high with `ret_cls` = 2 (task-switching transfer), the resume flag keeps its value.
- R11: When `rf_ld` is high, the resume flag is loaded from `rf_ld_val`, and this takes priority over any retirement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | SEL_W | Register select: addresses, then control, then status |
| reg_wdata | input | ADDR_W | Register write data |
| ist_vld | input | 1 | Instruction start strobe |
| ist_addr | input | ADDR_W | Address of the starting instruction |
| ret_vld | input | 1 | Instruction retire strobe |
| ret_cls | input | 2 | Retiring instruction class code |
| rf_ld | input | 1 | Direct resume flag load strobe |
| rf_ld_val | input | 1 | Value for the direct load and for the flags-restore load |
| dbg_fault | output | 1 | One-cycle debug fault request |
| dbg_status | output | NUM_BP | Sticky per-breakpoint match bits |

## Verification
The bench builds the unit with an 8-bit address and four breakpoints, so the whole 256-entry start-address space can be swept under every one of the 16 enable masks. Two breakpoints share an address, so the sweep also covers simultaneous matches and masks where only one of the pair is enabled. The resume flag cases go through every retire class, the direct load with and without a competing retirement, and a status write that coincides with a match. Expected status and fault values come from comparing each address with the programmed list in the bench.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
   typedef enum logic [1:0] {
      CLS_PLAIN   = 2'd0,
      CLS_RESTORE = 2'd1,
      CLS_TASKSW  = 2'd2,
      CLS_OTHER   = 2'd3
   } ret_cls_t;
endpackage

// File: rtl/brk_resume.sv
module brk_resume
   import dbg_brk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rf_ld,
   input  logic       rf_ld_val,
   input  logic       ret_vld,
   input  logic [1:0] ret_cls,
   output logic       rf_q
);
   logic     rf_d;
   ret_cls_t cls;

   assign cls = ret_cls_t'(ret_cls);

   always_comb begin
      rf_d = rf_q;
      if (rf_ld) begin
         rf_d = rf_ld_val;
      end else if (ret_vld) begin
         unique case (cls)
            CLS_RESTORE: rf_d = rf_ld_val;
            CLS_TASKSW:  rf_d = rf_q;
            default:     rf_d = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rf_q <= 1'b0;
      else        rf_q <= rf_d;
   end
endmodule

// File: rtl/brk_cmp_bank.sv
module brk_cmp_bank #(
   parameter int NUM_BP = 4,
   parameter int ADDR_W = 32,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   input  logic              ist_vld,
   input  logic [ADDR_W-1:0] ist_addr,
   input  logic [NUM_BP-1:0] bp_en,
   output logic [NUM_BP-1:0] hits
);
   for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
      logic [ADDR_W-1:0] addr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            addr_q <= '0;
         else if (reg_we && reg_sel == SEL_W'(i))
            addr_q <= reg_wdata;
      end

      assign hits[i] = ist_vld && bp_en[i] && (ist_addr == addr_q);
   end
endmodule

// File: rtl/brk_status.sv
module brk_status #(
   parameter int NUM_BP = 4,
   parameter int ADDR_W = 32,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   input  logic [NUM_BP-1:0] hits,
   input  logic              rf_q,
   output logic [NUM_BP-1:0] bp_en,
   output logic [NUM_BP-1:0] status_q,
   output logic              fault_q
);
   localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(NUM_BP);
   localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(NUM_BP + 1);

   logic              ctrl_wr;
   logic              stat_wr;
   logic [NUM_BP-1:0] stat_base;

   assign ctrl_wr   = reg_we && (reg_sel == SEL_CTRL);
   assign stat_wr   = reg_we && (reg_sel == SEL_STAT);
   assign stat_base = stat_wr ? reg_wdata[NUM_BP-1:0] : status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_en    <= '0;
         status_q <= '0;
         fault_q  <= 1'b0;
      end else begin
         if (ctrl_wr) bp_en <= reg_wdata[NUM_BP-1:0];
         status_q <= stat_base | hits;
         fault_q  <= (|hits) && !rf_q;
      end
   end
endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit #(
   parameter int NUM_BP = 4,
   parameter int ADDR_W = 32,
   localparam int SEL_W = $clog2(NUM_BP + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   input  logic              ist_vld,
   input  logic [ADDR_W-1:0] ist_addr,
   input  logic              ret_vld,
   input  logic [1:0]        ret_cls,
   input  logic              rf_ld,
   input  logic              rf_ld_val,
   output logic              dbg_fault,
   output logic [NUM_BP-1:0] dbg_status
);
   if (NUM_BP < 1 || NUM_BP > 16) begin : g_bad_num
      $error("NUM_BP must lie in 1..16");
   end
   if (ADDR_W < NUM_BP) begin : g_bad_width
      $error("ADDR_W must be at least NUM_BP");
   end

   logic [NUM_BP-1:0] hits;
   logic [NUM_BP-1:0] bp_en;
   logic              rf_q;

   brk_cmp_bank #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .ist_vld   (ist_vld),
      .ist_addr  (ist_addr),
      .bp_en     (bp_en),
      .hits      (hits)
   );

   brk_status #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .hits      (hits),
      .rf_q      (rf_q),
      .bp_en     (bp_en),
      .status_q  (dbg_status),
      .fault_q   (dbg_fault)
   );

   brk_resume u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .rf_ld     (rf_ld),
      .rf_ld_val (rf_ld_val),
      .ret_vld   (ret_vld),
      .ret_cls   (ret_cls),
      .rf_q      (rf_q)
   );
endmodule

// File: rtl/dbg_brk_unit_chk.sv
module dbg_brk_unit_chk #(
   parameter int NUM_BP = 4,
   parameter int SEL_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [SEL_W-1:0]  reg_sel,
   input logic              ist_vld,
   input logic              ret_vld,
   input logic [1:0]        ret_cls,
   input logic              rf_ld,
   input logic              rf_ld_val,
   input logic              rf_q,
   input logic              dbg_fault,
   input logic [NUM_BP-1:0] dbg_status
);
   logic stat_wr;
   assign stat_wr = reg_we && (reg_sel == SEL_W'(NUM_BP + 1));

   AST_FAULT_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_fault |-> $past(ist_vld)); // R4
   AST_FAULT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_fault |-> (dbg_status != '0)); // R4
   AST_FAULT_RF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_fault |-> !$past(rf_q)); // R7
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stat_wr) |-> (($past(dbg_status) & ~dbg_status) == '0)); // R6
   AST_RF_PLAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ret_vld && !rf_ld && (ret_cls == 2'd0 || ret_cls == 2'd3)) |-> !rf_q); // R8
   AST_RF_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ret_vld && ret_cls == 2'd1) |-> (rf_q == $past(rf_ld_val))); // R9
   AST_RF_TASKSW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ret_vld && !rf_ld && ret_cls == 2'd2) |-> (rf_q == $past(rf_q))); // R10
   AST_RF_LOAD_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rf_ld) |-> (rf_q == $past(rf_ld_val))); // R11
endmodule

bind dbg_brk_unit dbg_brk_unit_chk #(.NUM_BP(NUM_BP), .SEL_W(SEL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_sel    (reg_sel),
   .ist_vld    (ist_vld),
   .ret_vld    (ret_vld),
   .ret_cls    (ret_cls),
   .rf_ld      (rf_ld),
   .rf_ld_val  (rf_ld_val),
   .rf_q       (rf_q),
   .dbg_fault  (dbg_fault),
   .dbg_status (dbg_status)
);

// File: tb/dbg_brk_unit_tb.sv
module dbg_brk_unit_tb;
   localparam int NB = 4;
   localparam int AW = 8;
   localparam int SW = $clog2(NB + 2);
   localparam logic [SW-1:0] S_CTRL = SW'(NB);
   localparam logic [SW-1:0] S_STAT = SW'(NB + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [SW-1:0] reg_sel = '0;
   logic [AW-1:0] reg_wdata = '0;
   logic          ist_vld = 1'b0;
   logic [AW-1:0] ist_addr = '0;
   logic          ret_vld = 1'b0;
   logic [1:0]    ret_cls = '0;
   logic          rf_ld = 1'b0;
   logic          rf_ld_val = 1'b0;
   logic          dbg_fault;
   logic [NB-1:0] dbg_status;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [AW-1:0] bp [NB];

   always #10 clk = ~clk;

   dbg_brk_unit #(.NUM_BP(NB), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .ist_vld(ist_vld), .ist_addr(ist_addr),
      .ret_vld(ret_vld), .ret_cls(ret_cls), .rf_ld(rf_ld),
      .rf_ld_val(rf_ld_val), .dbg_fault(dbg_fault), .dbg_status(dbg_status)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [SW-1:0] sel, input logic [AW-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic start(input logic [AW-1:0] a);
      @(negedge clk);
      ist_vld = 1'b1; ist_addr = a;
      @(negedge clk);
      ist_vld = 1'b0;
   endtask

   task automatic retire(input logic [1:0] c, input logic v);
      @(negedge clk);
      ret_vld = 1'b1; ret_cls = c; rf_ld_val = v;
      @(negedge clk);
      ret_vld = 1'b0;
   endtask

   task automatic rfload(input logic v);
      @(negedge clk);
      rf_ld = 1'b1; rf_ld_val = v;
      @(negedge clk);
      rf_ld = 1'b0;
   endtask

   function automatic logic [NB-1:0] exp_hits(input logic [AW-1:0] a, input logic [NB-1:0] en);
      logic [NB-1:0] h;
      for (int i = 0; i < NB; i++) h[i] = en[i] && (a == bp[i]);
      return h;
   endfunction

   // probe breakpoint 0 (enabled) and report fault/status
   task automatic probe(input string tag, input bit exp_fault);
      start(bp[0]);
      chk(tag, int'(dbg_fault), int'(exp_fault));
      chk(tag, int'(dbg_status), 1);
      wr(S_STAT, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [NB-1:0] h;
      bp[0] = 8'h10; bp[1] = 8'h37; bp[2] = 8'h37; bp[3] = 8'hF0;
      repeat (3) @(negedge clk);
      chk("R1 fault", int'(dbg_fault), 0);
      chk("R1 status", int'(dbg_status), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 fault after release", int'(dbg_fault), 0);
      // enables are 0 and addresses are 0 after reset: start at 0 must not hit
      start(8'h00);
      chk("R1 R3 no hit with reset enables", int'(dbg_status), 0);

      for (int i = 0; i < NB; i++) wr(SW'(i), bp[i]);

      // R2 R3 R4 R5: full address sweep under every enable mask
      for (int m = 0; m < 16; m++) begin
         wr(S_CTRL, AW'(m));
         for (int a = 0; a < 256; a++) begin
            h = exp_hits(AW'(a), NB'(m));
            start(AW'(a));
            chk("R4 R5 R3 sweep status", int'(dbg_status), int'(h));
            chk("R4 R3 sweep fault", int'(dbg_fault), int'(|h));
            if (h != '0) begin
               wr(S_STAT, '0);
               chk("R4 one-cycle fault", int'(dbg_fault), 0);
               chk("R6 status cleared", int'(dbg_status), 0);
            end
         end
      end

      // R6 stickiness and software load of status
      wr(S_CTRL, 8'h0F);
      start(bp[3]);
      repeat (5) @(negedge clk);
      chk("R6 sticky", int'(dbg_status), 8);
      wr(S_STAT, 8'h05);
      chk("R6 write loads", int'(dbg_status), 5);
      wr(S_STAT, '0);
      // R6 write coinciding with a match
      @(negedge clk);
      reg_we = 1'b1; reg_sel = S_STAT; reg_wdata = 8'h02;
      ist_vld = 1'b1; ist_addr = bp[0];
      @(negedge clk);
      reg_we = 1'b0; ist_vld = 1'b0;
      chk("R6 write ORed with match", int'(dbg_status), 3);
      wr(S_STAT, '0);

      // R2 rewrite replaces address
      wr(SW'(3), 8'hA5);
      start(8'hF0);
      chk("R2 old address gone", int'(dbg_status), 0);
      start(8'hA5);
      chk("R2 new address hits", int'(dbg_status), 8);
      wr(S_STAT, '0);

      // R7 R8: flag suppresses, ordinary retire clears
      wr(S_CTRL, 8'h01);
      rfload(1'b1);
      probe("R7 suppressed", 1'b0);
      probe("R7 stays set without retire", 1'b0);
      retire(2'd0, 1'b1);
      probe("R8 plain retire clears", 1'b1);
      rfload(1'b1);
      retire(2'd3, 1'b1);
      probe("R8 class 3 clears", 1'b1);

      // R9 restore class loads from popped value
      retire(2'd1, 1'b1);
      probe("R9 restore loads 1", 1'b0);
      retire(2'd1, 1'b0);
      probe("R9 restore loads 0", 1'b1);

      // R10 task switch keeps
      rfload(1'b1);
      retire(2'd2, 1'b0);
      probe("R10 task switch keeps set", 1'b0);
      rfload(1'b0);
      retire(2'd2, 1'b1);
      probe("R10 task switch keeps clear", 1'b1);

      // R11 direct load wins over retire
      @(negedge clk);
      rf_ld = 1'b1; rf_ld_val = 1'b1; ret_vld = 1'b1; ret_cls = 2'd0;
      @(negedge clk);
      rf_ld = 1'b0; ret_vld = 1'b0;
      probe("R11 load beats plain retire", 1'b0);
      @(negedge clk);
      rf_ld = 1'b1; rf_ld_val = 1'b0; ret_vld = 1'b1; ret_cls = 2'd2;
      @(negedge clk);
      rf_ld = 1'b0; ret_vld = 1'b0;
      probe("R11 load beats task switch", 1'b1);

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule